// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block holds the colour lookup table of a display controller. The table has 256 colour entries. They are packed two to a 32-bit word, so 128 words are held in flops. A register bus writes and reads these words through a byte-addressed window. Byte-lane strobes allow partial writes. A bus read always returns the word exactly as it was written, including bits that play no part in the colour.

A second port serves the pixel pipeline. It takes an 8-bit pixel index and, one cycle later, presents the selected entry as three 8-bit colour channels. Each channel is a 5-bit field from the entry, widened by appending three zero bits. The top bit of each entry is an intensity flag that the lookup ignores. Conversion into any host colour format happens outside this block.

Top module: `clut_ram`

## Requirements
- R1: After synchronous reset, every word reads as zero, `bus_rdata` is zero, `pix_vld` is low and the three colour outputs are zero.
- R2: A bus access hits the table when `bus_addr` lies in 0x200 to 0x3FF; it selects word (`bus_addr` - 0x200) >> 2. A read with `bus_rd` puts the raw stored word on `bus_rdata` one cycle later. `bus_rdata` holds its value in cycles without `bus_rd`. A read and a write to the same word in the same cycle return the old word.
- R3: A write updates byte lane k (bits 8k+7 to 8k) only when `bus_wstrb[k]` is 1; the other lanes keep their values.
- R4: A write outside the window changes no word. A read outside the window returns zero.
- R5: Pixel index bits [7:1] select the word. Index bit 0 selects the half: 0 selects bits [15:0] and 1 selects bits [31:16].
- R6: Within the selected 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Each channel is output as {field, 3'b000}.
- R7: Entry bit 15 (the intensity flag) has no effect on the colour outputs.
- R8: `pix_vld` is high exactly one cycle after `pix_en`. The colour outputs change only in that cycle and hold otherwise.
- R9: A lookup and a write to the same word in the same cycle return the word's old contents. A lookup in the next cycle returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Bus write request |
| bus_rd | input | 1 | Bus read request |
| bus_addr | input | 12 | Byte address of the bus access |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| pix_en | input | 1 | Lookup request |
| pix_idx | input | 8 | Pixel colour index |
| pix_vld | output | 1 | Lookup result valid |
| pix_red | output | 8 | Widened red channel |
| pix_grn | output | 8 | Widened green channel |
| pix_blu | output | 8 | Widened blue channel |

## Verification
The bench builds the block with its default parameters: 128 words and a window base of 0x200. With these values, all 256 pixel indices can be looked up back to back. The bench also probes the addresses on both edges of the window: 0x1FC and 0x200 at the bottom, 0x3FC and 0x400 at the top. The same-cycle collisions (write with lookup, and write with bus read) are driven on purpose, so that the old-data rule is observed at the ports.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int CHAN_W  = 5;
    localparam int COL_W   = 8;
    localparam int ENT_W   = 16;
    localparam int FIELD_W = 3 * CHAN_W;   // colour bits of an entry, flag excluded
    localparam int PAD_W   = COL_W - CHAN_W;

    typedef struct packed {
        logic [COL_W-1:0] red;
        logic [COL_W-1:0] grn;
        logic [COL_W-1:0] blu;
    } rgb_t;

    // Widen one 5-bit channel by appending zero bits.
    function automatic logic [COL_W-1:0] widen(input logic [CHAN_W-1:0] c);
        return {c, {PAD_W{1'b0}}};
    endfunction

    // Expand the colour part of an entry (flag bit not passed in).
    function automatic rgb_t expand(input logic [FIELD_W-1:0] f);
        rgb_t o;
        o.red = widen(f[CHAN_W-1:0]);
        o.grn = widen(f[2*CHAN_W-1:CHAN_W]);
        o.blu = widen(f[3*CHAN_W-1:2*CHAN_W]);
        return o;
    endfunction

endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
    parameter int          AW    = 12,
    parameter int          WORDS = 128,
    parameter logic [11:0] BASE  = 12'h200
) (
    input  logic [AW-1:0]              addr,
    output logic                       hit,
    output logic [$clog2(WORDS)-1:0]   widx
);
    localparam int WA_W = $clog2(WORDS);
    localparam int SPAN = WORDS * 4;

    logic [AW-1:0] off;
    logic          dec_unused;

    always_comb begin
        off  = addr - AW'(BASE);
        hit  = (addr >= AW'(BASE)) && ({1'b0, addr} < (AW+1)'(BASE) + (AW+1)'(SPAN));
        widx = off[WA_W+1:2];
    end

    assign dec_unused = &{1'b0, off[1:0], off[AW-1:WA_W+2]};
endmodule

// File: rtl/clut_store.sv
module clut_store #(
    parameter int WORDS = 128,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(WORDS)-1:0]  wr_idx,
    input  logic [DW/8-1:0]           wr_strb,
    input  logic [DW-1:0]             wr_data,
    input  logic                      rd_en,
    input  logic                      rd_hit,
    input  logic [$clog2(WORDS)-1:0]  rd_idx,
    output logic [DW-1:0]             rd_data,
    input  logic                      lk_en,
    input  logic [$clog2(WORDS)-1:0]  lk_idx,
    output logic [DW-1:0]             lk_word
);
    localparam int LANES = DW / 8;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] wmask;

    // Expand byte strobes into a bit mask.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wmask[8*l +: 8] = {8{wr_strb[l]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= (mem[wr_idx] & ~wmask) | (wr_data & wmask);
        end
    end

    // Bus read port: old data on collision, zero outside the window.
    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_hit ? mem[rd_idx] : '0;
    end

    // Lookup read port.
    always_ff @(posedge clk) begin
        if (rst)        lk_word <= '0;
        else if (lk_en) lk_word <= mem[lk_idx];
    end
endmodule

// File: rtl/clut_unpack.sv
module clut_unpack
    import clut_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          half_in,
    input  logic [DW-1:0] word,
    output logic          vld,
    output rgb_t          rgb
);
    logic             half_q;
    logic [ENT_W-1:0] entry;
    logic             unp_unused;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= 1'b0;
            half_q <= 1'b0;
        end else begin
            vld <= en;
            if (en) half_q <= half_in;
        end
    end

    always_comb begin
        entry = half_q ? word[2*ENT_W-1:ENT_W] : word[ENT_W-1:0];
        rgb   = expand(entry[FIELD_W-1:0]);
    end

    assign unp_unused = &{1'b0, entry[ENT_W-1]};
endmodule

// File: rtl/clut_ram.sv
module clut_ram
    import clut_pkg::*;
#(
    parameter int          WORDS = 128,
    parameter logic [11:0] BASE  = 12'h200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [3:0]  bus_wstrb,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        pix_en,
    input  logic [7:0]  pix_idx,
    output logic        pix_vld,
    output logic [7:0]  pix_red,
    output logic [7:0]  pix_grn,
    output logic [7:0]  pix_blu
);
    localparam int WA_W = $clog2(WORDS);

    logic            hit;
    logic [WA_W-1:0] widx;
    logic [31:0]     lk_word;
    rgb_t            rgb;

    clut_decode #(.AW(12), .WORDS(WORDS), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .widx (widx)
    );

    clut_store #(.WORDS(WORDS), .DW(32)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && hit),
        .wr_idx  (widx),
        .wr_strb (bus_wstrb),
        .wr_data (bus_wdata),
        .rd_en   (bus_rd),
        .rd_hit  (hit),
        .rd_idx  (widx),
        .rd_data (bus_rdata),
        .lk_en   (pix_en),
        .lk_idx  (pix_idx[WA_W:1]),
        .lk_word (lk_word)
    );

    clut_unpack #(.DW(32)) u_unp (
        .clk     (clk),
        .rst     (rst),
        .en      (pix_en),
        .half_in (pix_idx[0]),
        .word    (lk_word),
        .vld     (pix_vld),
        .rgb     (rgb)
    );

    assign pix_red = rgb.red;
    assign pix_grn = rgb.grn;
    assign pix_blu = rgb.blu;
endmodule

// File: rtl/clut_ram_chk.sv
module clut_ram_chk #(
    parameter int          WORDS = 128,
    parameter logic [11:0] BASE  = 12'h200
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_rd,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic        pix_en,
    input logic        pix_vld,
    input logic [7:0]  pix_red,
    input logic [7:0]  pix_grn,
    input logic [7:0]  pix_blu
);
    logic in_win;
    assign in_win = (bus_addr >= BASE) && ({1'b0, bus_addr} < {1'b0, BASE} + 13'(WORDS * 4));

    p_vld_after_en_r8: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> pix_vld);

    p_no_vld_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> !pix_vld);

    p_colour_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(pix_red) && $stable(pix_grn) && $stable(pix_blu)));

    p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (rst)
        pix_vld |-> (pix_red[2:0] == 3'b0 && pix_grn[2:0] == 3'b0 && pix_blu[2:0] == 3'b0));

    p_outside_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_win) |=> (bus_rdata == 32'h0));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind clut_ram clut_ram_chk #(.WORDS(WORDS), .BASE(BASE)) u_chk (.*);

// File: tb/clut_ram_test.sv
module clut_ram_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pix_en = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic        pix_vld;
    logic [7:0]  pix_red, pix_grn, pix_blu;

    always #2.5 clk = ~clk;   // 200 MHz

    clut_ram uut (.*);

    typedef struct {
        logic [23:0] rgb;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model [128];
    logic [23:0] last_rgb = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    function automatic logic [23:0] colour_of(input logic [7:0] idx);
        logic [31:0] w;
        logic [15:0] h;
        w = model[idx[7:1]];
        h = idx[0] ? w[31:16] : w[15:0];
        return {h[4:0], 3'b000, h[9:5], 3'b000, h[14:10], 3'b000};
    endfunction

    function automatic bit in_win(input logic [11:0] a);
        return a >= 12'h200 && a < 12'h400;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [3:0] s, input logic [31:0] d);
        if (in_win(a))
            for (int l = 0; l < 4; l++)
                if (s[l]) model[(a - 12'h200) >> 2][8*l +: 8] = d[8*l +: 8];
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wstrb = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, s, d);
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check32(req, bus_rdata, exp);
    endtask

    task automatic lookup(input logic [7:0] idx, input string req);
        exp_t e;
        @(negedge clk);
        pix_en = 1'b1; pix_idx = idx;
        e.rgb = colour_of(idx); e.req = req;
        sb.push_back(e);
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    // Monitor: pops expected colours as results appear.
    always @(negedge clk) begin
        if (!rst && pix_vld) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R8: actual unexpected valid expected no result");
            end else begin
                exp_t e;
                e = sb.pop_front();
                last_rgb = e.rgb;
                if ({pix_red, pix_grn, pix_blu} !== e.rgb) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.req,
                             {pix_red, pix_grn, pix_blu}, e.rgb);
                end
            end
        end
    end

    initial begin
        for (int w = 0; w < 128; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check32("R1 valid", {31'b0, pix_vld}, 32'h0);
        check32("R1 rdata", bus_rdata, 32'h0);
        check32("R1 colour", {8'h0, pix_red, pix_grn, pix_blu}, 32'h0);
        bus_read(12'h200, 32'h0, "R1 word0");
        bus_read(12'h3FC, 32'h0, "R1 last word");
        lookup(8'hFF, "R1 lookup");

        // R2 fill every word, read back raw
        for (int w = 0; w < 128; w++)
            bus_write(12'h200 + 12'(w * 4), 4'hF, (w + 1) * 32'h9E37_79B1 ^ 32'h8000_0000);
        bus_read(12'h200, model[0], "R2 first");
        bus_read(12'h3FC, model[127], "R2 last");
        bus_read(12'h2A4, model[41], "R2 middle");

        // R5 R6 all indices back to back
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            exp_t e;
            pix_en = 1'b1; pix_idx = 8'(i);
            e.rgb = colour_of(8'(i)); e.req = "R5/R6 sweep";
            sb.push_back(e);
            @(negedge clk);
        end
        pix_en = 1'b0;

        // R6 distinct channel values
        bus_write(12'h210, 4'hF, {1'b0, 5'h11, 5'h0A, 5'h1F, 1'b0, 5'h03, 5'h1C, 5'h05});
        lookup(8'h08, "R6 low half");
        lookup(8'h09, "R6 high half");

        // R7 intensity flag ignored; raw read still shows it
        bus_write(12'h214, 4'hF, 32'h8000_7FFF);
        lookup(8'h0A, "R7 flag clear");
        lookup(8'h0B, "R7 flag set zero");
        bus_write(12'h214, 4'hF, 32'h0000_FFFF);
        lookup(8'h0A, "R7 flag set");
        bus_read(12'h214, 32'h0000_FFFF, "R7 raw kept");

        // R3 byte strobes
        bus_write(12'h300, 4'hF, 32'h1234_5678);
        bus_write(12'h300, 4'b0101, 32'hFFFF_FFFF);
        bus_read(12'h300, 32'h12FF_56FF, "R3 lanes 0 2");
        bus_write(12'h300, 4'b1000, 32'hAB00_0000);
        bus_read(12'h300, 32'hABFF_56FF, "R3 lane 3");

        // R4 outside window
        bus_write(12'h1FC, 4'hF, 32'hDEAD_BEEF);
        bus_write(12'h400, 4'hF, 32'hDEAD_BEEF);
        bus_write(12'hFFC, 4'hF, 32'hDEAD_BEEF);
        bus_write(12'h000, 4'hF, 32'hDEAD_BEEF);
        bus_read(12'h1FC, 32'h0, "R4 below");
        bus_read(12'h400, 32'h0, "R4 above");
        bus_read(12'h200, model[0], "R4 first untouched");
        bus_read(12'h3FC, model[127], "R4 last untouched");
        bus_read(12'h000, 32'h0, "R4 zero addr");

        // R9 write and lookup same word, same cycle
        @(negedge clk);
        begin
            exp_t e;
            bus_wr = 1'b1; bus_addr = 12'h220; bus_wstrb = 4'hF; bus_wdata = 32'h7C1F_03E0;
            pix_en = 1'b1; pix_idx = 8'h10;
            e.rgb = colour_of(8'h10); e.req = "R9 old data";
            sb.push_back(e);
            @(negedge clk);
            bus_wr = 1'b0; pix_en = 1'b0;
            model_write(12'h220, 4'hF, 32'h7C1F_03E0);
        end
        lookup(8'h10, "R9 new data");
        lookup(8'h11, "R9 new upper");

        // R2 read and write same word, same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h224; bus_wstrb = 4'hF; bus_wdata = 32'h0F0F_0F0F;
        begin
            logic [31:0] old;
            old = model[9];
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            model_write(12'h224, 4'hF, 32'h0F0F_0F0F);
            check32("R2 read collision old", bus_rdata, old);
        end
        bus_read(12'h224, 32'h0F0F_0F0F, "R2 after collision");

        // R8 hold while idle, then R2 rdata hold
        bus_write(12'h210, 4'hF, 32'h0);
        repeat (3) @(negedge clk);
        check32("R8 idle valid", {31'b0, pix_vld}, 32'h0);
        check32("R8 idle colour", {8'h0, pix_red, pix_grn, pix_blu}, {8'h0, last_rgb});
        check32("R2 rdata hold", bus_rdata, 32'h0F0F_0F0F);
        check32("R8 queue drained", 32'(sb.size()), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule